// File: doc/BRIEF.md
# Int8 Tensor Multiply-Accumulate Engine

This block runs one long tensor command at a time. A command names a number of operand beats, from 1 to 512. On each beat the engine takes one 512-bit word from stream A and one from stream B. It treats each word as 64 signed 8-bit elements, multiplies the elements in matching positions, and adds the products into sixteen 32-bit accumulators. Together those accumulators form one 512-bit row.

While a command runs, `busy_o` stays high so that the issuing scalar pipeline holds still. A beat whose two operands are not both valid stalls the sequence and uses up none of the count. When the last beat has been added, `done_o` pulses for one cycle. The full accumulator row is visible on `acc_o` at all times. A command can either zero the row before it starts or keep adding to the values left by earlier commands.

Top module: `tme_engine`

## Requirements
- R1: `cmd_ready_o` is high exactly when `busy_o` is low. A command is accepted on a rising edge where `cmd_valid_i` and `cmd_ready_o` are both high. `busy_o` is high in the cycle after acceptance. While busy, `cmd_valid_i` is ignored.
- R2: `cmd_len_i` holds the beat count minus one. A command consumes exactly `cmd_len_i`+1 operand beats, so the 9-bit field covers 1 to 512 beats.
- R3: A beat is an edge where `busy_o`, `a_valid_i` and `b_valid_i` are all high. `op_ready_o` equals `busy_o`. A busy cycle without both valids leaves `acc_o` unchanged and consumes no count.
- R4: Lane i is `acc_o[32i+31:32i]`, for i from 0 to 15. On each beat, lane i adds the sum over j = 0..3 of signed(A byte 4i+j) × signed(B byte 4i+j). Byte k is bits [8k+7:8k] of its operand.
- R5: Accumulation wraps modulo 2^32 and does not saturate.
- R6: If `cmd_clr_i` is 1 at acceptance, `acc_o` reads zero in the cycle after acceptance. If it is 0, the lanes keep their earlier values and accumulation continues from them.
- R7: `done_o` is high for exactly one cycle: the cycle after the edge that commits the last beat. In that same cycle `busy_o` is low, and `acc_o` already holds the final sums.
- R8: While `rst_ni` is low, `acc_o` is zero and `busy_o`, `done_o` and `op_ready_o` are low.
- R9: While idle, `a_valid_i`, `b_valid_i` and the operand data have no effect on `acc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine can take a command |
| cmd_len_i | input | 9 | Beat count minus one |
| cmd_clr_i | input | 1 | Zero the accumulators at acceptance |
| a_valid_i | input | 1 | Stream A word valid |
| a_data_i | input | 512 | Stream A word, 64 signed bytes |
| b_valid_i | input | 1 | Stream B word valid |
| b_data_i | input | 512 | Stream B word, 64 signed bytes |
| op_ready_o | output | 1 | Operands are consumed when both are valid |
| busy_o | output | 1 | Command running; the scalar pipeline holds |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | 512 | Sixteen 32-bit accumulator lanes |

## Verification
Every result in this block is due exactly one clock edge after the stimulus that causes it:
- `busy_o` rises one edge after command acceptance, and a cleared row reads zero in that same cycle.
- Each beat's sum appears on `acc_o` one edge after that beat.
- `done_o` rises one edge after the final beat, together with the fall of `busy_o`.

The bench drives all inputs on the falling clock edge. It samples outputs on the next falling edge, so each check sits in the cycle right after the rising edge that should have produced the result. Stall cycles and idle cycles are sampled the same way, which shows that nothing moved.

// File: rtl/tme_pkg.sv
package tme_pkg;
  localparam int unsigned ELEM_W         = 8;
  localparam int unsigned OP_W           = 512;
  localparam int unsigned ACC_W          = 32;
  localparam int unsigned ELEMS_PER_LANE = 4;
  localparam int unsigned LEN_W          = 9;
endpackage

// File: rtl/tme_seq.sv
module tme_seq #(
  parameter int unsigned LEN_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             cmd_clr_i,
  input  logic             a_valid_i,
  input  logic             b_valid_i,
  output logic             cmd_ready_o,
  output logic             op_ready_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             clr_o,
  output logic             beat_o
);
  logic             busy_q, done_q;
  logic [LEN_W-1:0] rem_q;
  logic             accept, beat, last;

  assign accept = cmd_valid_i & ~busy_q;
  assign beat   = busy_q & a_valid_i & b_valid_i;
  assign last   = beat && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        rem_q  <= cmd_len_i;
      end else if (last) begin
        busy_q <= 1'b0;
      end else if (beat) begin
        rem_q  <= rem_q - 1'b1;
      end
    end
  end

  assign cmd_ready_o = ~busy_q;
  assign op_ready_o  = busy_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign clr_o       = accept & cmd_clr_i;
  assign beat_o      = beat;
endmodule

// File: rtl/tme_lane.sv
module tme_lane #(
  parameter int unsigned ELEM_W = 8,
  parameter int unsigned ELEMS  = 4,
  parameter int unsigned ACC_W  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic [ELEMS*ELEM_W-1:0] a_i,
  input  logic [ELEMS*ELEM_W-1:0] b_i,
  output logic [ACC_W-1:0]        acc_o
);
  localparam int unsigned PROD_W = 2 * ELEM_W;

  logic signed [PROD_W-1:0] prod [ELEMS];
  logic        [ACC_W-1:0]  sum;
  logic        [ACC_W-1:0]  acc_q;

  for (genvar j = 0; j < ELEMS; j++) begin : g_mul
    assign prod[j] = $signed(a_i[j*ELEM_W +: ELEM_W]) * $signed(b_i[j*ELEM_W +: ELEM_W]);
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < ELEMS; j++) begin
      sum = sum + {{(ACC_W-PROD_W){prod[j][PROD_W-1]}}, prod[j]};
    end
  end

  // wraps modulo 2^ACC_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + sum;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/tme_engine.sv
module tme_engine
  import tme_pkg::*;
#(
  parameter int unsigned P_ELEM_W = ELEM_W,
  parameter int unsigned P_OP_W   = OP_W,
  parameter int unsigned P_ACC_W  = ACC_W,
  parameter int unsigned P_EPL    = ELEMS_PER_LANE,
  parameter int unsigned P_LEN_W  = LEN_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_valid_i,
  output logic                          cmd_ready_o,
  input  logic [P_LEN_W-1:0]            cmd_len_i,
  input  logic                          cmd_clr_i,
  input  logic                          a_valid_i,
  input  logic [P_OP_W-1:0]             a_data_i,
  input  logic                          b_valid_i,
  input  logic [P_OP_W-1:0]             b_data_i,
  output logic                          op_ready_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [P_OP_W/(P_ELEM_W*P_EPL)*P_ACC_W-1:0] acc_o
);
  localparam int unsigned LANE_IN_W = P_ELEM_W * P_EPL;
  localparam int unsigned LANES     = P_OP_W / LANE_IN_W;

  logic clr, beat;

  tme_seq #(.LEN_W(P_LEN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_len_i   (cmd_len_i),
    .cmd_clr_i   (cmd_clr_i),
    .a_valid_i   (a_valid_i),
    .b_valid_i   (b_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .op_ready_o  (op_ready_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .clr_o       (clr),
    .beat_o      (beat)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tme_lane #(
      .ELEM_W (P_ELEM_W),
      .ELEMS  (P_EPL),
      .ACC_W  (P_ACC_W)
    ) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (beat),
      .a_i    (a_data_i[i*LANE_IN_W +: LANE_IN_W]),
      .b_i    (b_data_i[i*LANE_IN_W +: LANE_IN_W]),
      .acc_o  (acc_o[i*P_ACC_W +: P_ACC_W])
    );
  end
endmodule

// File: rtl/tme_engine_chk.sv
module tme_engine_chk #(
  parameter int unsigned LEN_W = 9,
  parameter int unsigned ROW_W = 512
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic [LEN_W-1:0] cmd_len_i,
  input logic             cmd_clr_i,
  input logic             a_valid_i,
  input logic             b_valid_i,
  input logic             op_ready_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [ROW_W-1:0] acc_o
);
  logic             acc_evt, beat_evt;
  logic [LEN_W:0]   beats_q;
  logic [LEN_W-1:0] len_q;

  assign acc_evt  = cmd_valid_i & cmd_ready_o;
  assign beat_evt = busy_o & a_valid_i & b_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beats_q <= '0;
      len_q   <= '0;
    end else if (acc_evt) begin
      beats_q <= '0;
      len_q   <= cmd_len_i;
    end else if (beat_evt) begin
      beats_q <= beats_q + 1'b1;
    end
  end

  AST_READY_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o == !busy_o); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_evt |=> busy_o); // R1
  AST_BEAT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (beats_q == ({1'b0, len_q} + 1'b1))); // R2
  AST_OP_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_ready_o == busy_o); // R3
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat_evt && !(acc_evt && cmd_clr_i)) |=> $stable(acc_o)); // R3
  AST_STALL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(a_valid_i && b_valid_i)) |=> busy_o); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_evt && cmd_clr_i) |=> (acc_o == '0)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R7
  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && acc_o == '0)); // R8
endmodule

bind tme_engine tme_engine_chk #(
  .LEN_W (P_LEN_W),
  .ROW_W (P_OP_W/(P_ELEM_W*P_EPL)*P_ACC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_len_i   (cmd_len_i),
  .cmd_clr_i   (cmd_clr_i),
  .a_valid_i   (a_valid_i),
  .b_valid_i   (b_valid_i),
  .op_ready_o  (op_ready_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .acc_o       (acc_o)
);

// File: tb/tme_engine_tb.sv
module tme_engine_tb;
  localparam int LANES = 16;
  localparam int OP_W  = 512;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic             cmd_ready_o;
  logic [8:0]       cmd_len_i = '0;
  logic             cmd_clr_i = 1'b0;
  logic             a_valid_i = 1'b0;
  logic [OP_W-1:0]  a_data_i = '0;
  logic             b_valid_i = 1'b0;
  logic [OP_W-1:0]  b_data_i = '0;
  logic             op_ready_o, busy_o, done_o;
  logic [OP_W-1:0]  acc_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [LANES];

  always #4 clk_i = ~clk_i;

  tme_engine u_dut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_len_i, .cmd_clr_i,
    .a_valid_i, .a_data_i, .b_valid_i, .b_data_i, .op_ready_o,
    .busy_o, .done_o, .acc_o
  );

  function automatic logic [OP_W-1:0] model_row();
    logic [OP_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*32 +: 32] = model[i];
    return r;
  endfunction

  function automatic logic [OP_W-1:0] rand_word();
    logic [OP_W-1:0] w;
    for (int k = 0; k < OP_W/32; k++) w[k*32 +: 32] = $urandom;
    return w;
  endfunction

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_row(string tag);
    logic [OP_W-1:0] exp;
    exp = model_row();
    checks++;
    if (acc_o !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, acc_o, exp);
    end
  endtask

  function automatic void model_add(logic [OP_W-1:0] a, logic [OP_W-1:0] b);
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < 4; j++) begin
        int k, p;
        k = 4*i + j;
        p = int'($signed(a[8*k +: 8])) * int'($signed(b[8*k +: 8]));
        model[i] = model[i] + 32'(p);
      end
    end
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < LANES; i++) model[i] = '0;
  endfunction

  // at a falling edge on entry and exit
  task automatic send_cmd(logic [8:0] len, logic clr);
    cmd_valid_i = 1'b1; cmd_len_i = len; cmd_clr_i = clr;
    chk_bit("R1 ready when idle", cmd_ready_o, 1'b1);
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_clr_i = 1'b0;
    chk_bit("R1 busy after accept", busy_o, 1'b1);
    if (clr) begin
      model_clear();
      chk_row("R6 cleared at accept");
    end
  endtask

  task automatic beat(logic [OP_W-1:0] a, logic [OP_W-1:0] b);
    a_valid_i = 1'b1; b_valid_i = 1'b1; a_data_i = a; b_data_i = b;
    model_add(a, b);
    @(negedge clk_i);
    a_valid_i = 1'b0; b_valid_i = 1'b0;
  endtask

  task automatic check_done(string tag);
    chk_bit({tag, " R7 done high"}, done_o, 1'b1);
    chk_bit({tag, " R7 busy low"}, busy_o, 1'b0);
    chk_row({tag, " R4 final sums"});
    @(negedge clk_i);
    chk_bit({tag, " R7 done one cycle"}, done_o, 1'b0);
  endtask

  task automatic t_reset();
    chk_bit("R8 busy in reset", busy_o, 1'b0);
    chk_bit("R8 done in reset", done_o, 1'b0);
    chk_bit("R8 op_ready in reset", op_ready_o, 1'b0);
    model_clear();
    chk_row("R8 acc in reset");
    @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
    chk_bit("R1 idle after reset", cmd_ready_o, 1'b1);
  endtask

  task automatic t_single();
    send_cmd(9'd0, 1'b1);
    chk_bit("R3 op_ready while busy", op_ready_o, 1'b1);
    beat(rand_word(), rand_word());
    check_done("R2 single beat");
  endtask

  task automatic t_stall_continue();
    send_cmd(9'd3, 1'b0);
    for (int n = 0; n < 4; n++) begin
      chk_bit("R2 no early done", done_o, 1'b0);
      a_valid_i = 1'b1; b_valid_i = 1'b0; a_data_i = rand_word(); b_data_i = rand_word();
      @(negedge clk_i);
      a_valid_i = 1'b0;
      chk_row("R3 stall holds acc");
      chk_bit("R3 stall keeps busy", busy_o, 1'b1);
      beat(rand_word(), rand_word());
      chk_row("R4 running sum");
    end
    check_done("R6 no-clear continue");
  endtask

  task automatic t_idle_ignored();
    for (int n = 0; n < 3; n++) begin
      a_valid_i = 1'b1; b_valid_i = 1'b1; a_data_i = rand_word(); b_data_i = rand_word();
      @(negedge clk_i);
    end
    a_valid_i = 1'b0; b_valid_i = 1'b0;
    chk_row("R9 idle operands ignored");
    chk_bit("R9 still idle", busy_o, 1'b0);
  endtask

  task automatic t_cmd_while_busy();
    send_cmd(9'd1, 1'b1);
    cmd_valid_i = 1'b1; cmd_len_i = 9'd0; cmd_clr_i = 1'b1;
    chk_bit("R1 not ready while busy", cmd_ready_o, 1'b0);
    beat(rand_word(), rand_word());
    chk_bit("R1 busy ignores cmd", busy_o, 1'b1);
    beat(rand_word(), rand_word());
    chk_bit("R7 done", done_o, 1'b1);
    chk_bit("R1 ready in done cycle", cmd_ready_o, 1'b1);
    chk_row("R4 two-beat sums");
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_clr_i = 1'b0;
    model_clear();
    chk_bit("R1 queued cmd accepted", busy_o, 1'b1);
    chk_row("R6 queued clear");
    beat(rand_word(), rand_word());
    check_done("R2 queued cmd");
  endtask

  task automatic t_wrap();
    logic [OP_W-1:0] m128;
    m128 = {64{8'h80}};
    for (int c = 0; c < 128; c++) begin
      send_cmd(9'd511, c == 0);
      for (int n = 0; n < 512; n++) begin
        if (n == 511) chk_bit("R2 no done before beat 512", done_o, 1'b0);
        beat(m128, m128);
      end
      chk_bit("R2 done after 512 beats", done_o, 1'b1);
      if (c == 63) begin
        checks++;
        if (acc_o[31:0] !== 32'h8000_0000) begin
          errors++;
          $display("FAIL R5 half sum: actual=%h expected=80000000", acc_o[31:0]);
        end
      end
      @(negedge clk_i);
    end
    chk_row("R5 wrap to zero");
    checks++;
    if (acc_o !== '0) begin
      errors++;
      $display("FAIL R5 wrap: actual=%h expected=0", acc_o);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_single();
    t_stall_continue();
    t_idle_ignored();
    t_cmd_while_busy();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule